// File: doc/BRIEF.md
# Current-Regulated Frequency Ramp Controller

This block is a digital replacement for the control node of a ballast oscillator. It holds an unsigned control word. A larger word selects a higher switching frequency, and the word feeds a downstream period lookup. An operating-mode code from the surrounding sequencer selects how the word moves:

- **Preheat:** the word regulates peak load current. It drifts slowly downward and jumps upward quickly while a peak-over-reference flag is high.
- **Ignition:** it ramps linearly toward the minimum-frequency end.
- **Dim:** it slews down at a medium rate, and each phase-error pulse adds a fixed upward nudge.

A halt mode, used for undervoltage and fault, forces the word to full scale. A clear input does the same.

Slew steps are applied on ticks from a programmable prescaler, so software-independent ramp times can be set by a single limit input. Phase-error nudges are applied on the clock edge where they arrive, not on a tick. A registered flag reports when the word is below a programmable dim threshold. The sequencer uses this flag to end ignition.

Top module: `frq_ramp_ctrl`

## Requirements
- R1: While reset is asserted, in halt mode (code 2'b00), or while `clear_i` is high, the word becomes full scale (all ones, the highest frequency) at the next edge. The dim flag is then low.
- R2: In preheat mode (code 2'b01) with `peak_hi_i` low, each prescaler tick lowers the word by SLOW_STEP.
- R3: In preheat mode with `peak_hi_i` high, each tick raises the word by SLOW_STEP*UP_MULT (60 times the slow step by default).
- R4: In ignition mode (code 2'b10), each tick lowers the word by SLOW_STEP, and `peak_hi_i` has no effect.
- R5: In dim mode (code 2'b11), each tick lowers the word by SLOW_STEP*DIM_MULT (15 times the slow step by default).
- R6: In dim mode, every clock edge with `phase_err_i` high adds NUDGE to the word, together with any tick step on the same edge. Outside dim mode, `phase_err_i` has no effect.
- R7: The word saturates at 0 and at full scale and never wraps.
- R8: A tick occurs on an edge when the prescaler count has reached `presc_limit_i`, giving one tick every `presc_limit_i`+1 active cycles. The count restarts from zero during halt or clear. Between ticks the word changes only through dim-mode nudges.
- R9: `below_dim_o` is registered together with the word. It is high exactly when the new word is less than the `dim_thresh_i` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode: 00 halt, 01 preheat, 10 ignition, 11 dim |
| clear_i | input | 1 | Forces the word to full scale and restarts the prescaler |
| peak_hi_i | input | 1 | Peak load current above reference (used in preheat) |
| phase_err_i | input | 1 | Phase-error pulse, one nudge per high cycle (used in dim) |
| presc_limit_i | input | PW | Prescaler terminal count; tick period is limit+1 cycles |
| dim_thresh_i | input | W | Threshold for the below-dim flag |
| word_o | output | W | Frequency control word |
| below_dim_o | output | 1 | Word is below the dim threshold |

## Verification
The preheat tests alternate bursts of the peak flag with quiet stretches. This separates the fast rise from the slow fall and shows the rise clipping at full scale. A long ignition run at a one-cycle tick period drives the word into zero, with the peak flag toggling to show it is ignored. It also flips the dim flag at a chosen threshold. Dim mode is tried with a steady stream of phase-error pulses, which must win against the down slew and saturate high, and with sparse random pulses, where nudges and ticks land on the same edge. A restart with a prescaler limit of four pins down the exact edge of the first tick, and a one-cycle clear inside dim mode shows the immediate return to full scale.

// File: rtl/frq_ramp_pkg.sv
package frq_ramp_pkg;

    typedef enum logic [1:0] {
        MODE_HALT    = 2'b00,
        MODE_PREHEAT = 2'b01,
        MODE_IGNITE  = 2'b10,
        MODE_DIM     = 2'b11
    } ramp_mode_e;

endpackage

// File: rtl/frq_ramp_tick.sv
module frq_ramp_tick #(
    parameter int PW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hold_i,
    input  logic [PW-1:0] limit_i,
    output logic          tick_o
);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q >= limit_i);

    always_comb begin
        if (hold_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/frq_ramp_slew.sv
module frq_ramp_slew
    import frq_ramp_pkg::*;
#(
    parameter int W         = 12,
    parameter int SLOW_STEP = 1,
    parameter int UP_MULT   = 60,
    parameter int DIM_MULT  = 15,
    parameter int NUDGE     = 8
) (
    input  logic [1:0]   mode_i,
    input  logic         peak_hi_i,
    input  logic         phase_err_i,
    input  logic         tick_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] word_o
);

    // Headroom for the largest step plus sign
    localparam int SW = W + 14;
    localparam logic signed [SW-1:0] SLOW_S  = SW'(SLOW_STEP);
    localparam logic signed [SW-1:0] UP_S    = SW'(SLOW_STEP * UP_MULT);
    localparam logic signed [SW-1:0] DIM_S   = SW'(SLOW_STEP * DIM_MULT);
    localparam logic signed [SW-1:0] NUDGE_S = SW'(NUDGE);
    localparam logic signed [SW-1:0] FULL_S  = SW'((64'd1 << W) - 64'd1);

    ramp_mode_e             mode;
    logic signed [SW-1:0]   delta;
    logic signed [SW-1:0]   acc;

    assign mode = ramp_mode_e'(mode_i);

    always_comb begin
        delta = '0;
        if (tick_i) begin
            case (mode)
                MODE_PREHEAT: delta = peak_hi_i ? UP_S : -SLOW_S;
                MODE_IGNITE:  delta = -SLOW_S;
                MODE_DIM:     delta = -DIM_S;
                default:      delta = '0;
            endcase
        end
        if (mode == MODE_DIM && phase_err_i) begin
            delta = delta + NUDGE_S;
        end
        acc = $signed({{(SW-W){1'b0}}, word_i}) + delta;
        if (acc[SW-1]) begin
            word_o = '0;
        end else if (acc > FULL_S) begin
            word_o = '1;
        end else begin
            word_o = acc[W-1:0];
        end
    end

endmodule

// File: rtl/frq_ramp_ctrl.sv
module frq_ramp_ctrl
    import frq_ramp_pkg::*;
#(
    parameter int W         = 12,
    parameter int PW        = 8,
    parameter int SLOW_STEP = 1,
    parameter int UP_MULT   = 60,
    parameter int DIM_MULT  = 15,
    parameter int NUDGE     = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    mode_i,
    input  logic          clear_i,
    input  logic          peak_hi_i,
    input  logic          phase_err_i,
    input  logic [PW-1:0] presc_limit_i,
    input  logic [W-1:0]  dim_thresh_i,
    output logic [W-1:0]  word_o,
    output logic          below_dim_o
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         below;
    } ramp_state_t;

    ramp_state_t  st_d, st_q;
    logic         hold;
    logic         tick;
    logic [W-1:0] word_next;

    assign hold = (ramp_mode_e'(mode_i) == MODE_HALT) || clear_i;

    frq_ramp_tick #(
        .PW(PW)
    ) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hold_i  (hold),
        .limit_i (presc_limit_i),
        .tick_o  (tick)
    );

    frq_ramp_slew #(
        .W         (W),
        .SLOW_STEP (SLOW_STEP),
        .UP_MULT   (UP_MULT),
        .DIM_MULT  (DIM_MULT),
        .NUDGE     (NUDGE)
    ) u_slew (
        .mode_i      (mode_i),
        .peak_hi_i   (peak_hi_i),
        .phase_err_i (phase_err_i),
        .tick_i      (tick),
        .word_i      (st_q.word),
        .word_o      (word_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.word  = hold ? '1 : word_next;
        st_d.below = (st_d.word < dim_thresh_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.word  <= '1;
            st_q.below <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o      = st_q.word;
    assign below_dim_o = st_q.below;

endmodule

// File: rtl/frq_ramp_chk.sv
module frq_ramp_chk
    import frq_ramp_pkg::*;
#(
    parameter int W         = 12,
    parameter int SLOW_STEP = 1,
    parameter int DIM_MULT  = 15
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [1:0]   mode_i,
    input logic         clear_i,
    input logic         peak_hi_i,
    input logic         phase_err_i,
    input logic         tick,
    input logic [W-1:0] dim_thresh_i,
    input logic [W-1:0] word_o,
    input logic         below_dim_o
);

    localparam logic [W-1:0] FULL_W = '1;

    AST_HALT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_HALT || clear_i) |=> (word_o == FULL_W && !below_dim_o)); // R1

    AST_PH_SLOW_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_PREHEAT && !peak_hi_i && !clear_i) |=>
        (word_o <= $past(word_o) && ($past(word_o) - word_o) <= W'(SLOW_STEP))); // R2

    AST_PH_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_PREHEAT && peak_hi_i && !clear_i) |=> (word_o >= $past(word_o))); // R3

    AST_IGN_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_IGNITE && !clear_i) |=> (word_o <= $past(word_o))); // R4

    AST_DIM_DROP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_DIM && !clear_i) |=>
        (word_o >= $past(word_o) || ($past(word_o) - word_o) <= W'(SLOW_STEP * DIM_MULT))); // R5

    AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick && mode_i != MODE_HALT && !clear_i && !(mode_i == MODE_DIM && phase_err_i))
        |=> $stable(word_o)); // R8

    AST_FLAG_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (below_dim_o == (word_o < $past(dim_thresh_i)))); // R9

endmodule

bind frq_ramp_ctrl frq_ramp_chk #(
    .W         (W),
    .SLOW_STEP (SLOW_STEP),
    .DIM_MULT  (DIM_MULT)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .clear_i      (clear_i),
    .peak_hi_i    (peak_hi_i),
    .phase_err_i  (phase_err_i),
    .tick         (tick),
    .dim_thresh_i (dim_thresh_i),
    .word_o       (word_o),
    .below_dim_o  (below_dim_o)
);

// File: tb/frq_ramp_ctrl_tb.sv
module frq_ramp_ctrl_tb;

    localparam int W     = 12;
    localparam int PW    = 8;
    localparam int SLOW  = 1;
    localparam int UPM   = 60;
    localparam int DIMM  = 15;
    localparam int NUDGE = 8;
    localparam int FULL  = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          clear = 1'b0;
    logic          peak = 1'b0;
    logic          phase = 1'b0;
    logic [PW-1:0] limit = 8'd3;
    logic [W-1:0]  thresh = 12'd3000;
    logic [W-1:0]  word;
    logic          below;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    int    m_word = FULL;
    int    m_cnt = 0;
    bit    m_below = 1'b0;
    string m_req = "R1";

    always #10 clk = ~clk;

    frq_ramp_ctrl #(
        .W(W), .PW(PW), .SLOW_STEP(SLOW), .UP_MULT(UPM), .DIM_MULT(DIMM), .NUDGE(NUDGE)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .clear_i(clear),
        .peak_hi_i(peak), .phase_err_i(phase), .presc_limit_i(limit),
        .dim_thresh_i(thresh), .word_o(word), .below_dim_o(below)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = FULL; m_cnt = 0; m_below = 1'b0; m_req = "R1";
        end else if (mode == 2'b00 || clear) begin
            m_word = FULL; m_cnt = 0; m_req = "R1";
            m_below = (m_word < int'(thresh));
        end else begin
            int  nxt;
            bit  tk;
            tk  = (m_cnt >= int'(limit));
            nxt = m_word;
            m_req = "R8";
            if (tk) begin
                case (mode)
                    2'b01: begin nxt = peak ? nxt + SLOW*UPM : nxt - SLOW; m_req = peak ? "R3" : "R2"; end
                    2'b10: begin nxt = nxt - SLOW; m_req = "R4"; end
                    default: begin nxt = nxt - SLOW*DIMM; m_req = "R5"; end
                endcase
            end
            if (mode == 2'b11 && phase) begin nxt = nxt + NUDGE; m_req = "R6"; end
            if (nxt < 0 || nxt > FULL) m_req = "R7";
            if (nxt < 0) nxt = 0;
            if (nxt > FULL) nxt = FULL;
            m_word = nxt;
            m_cnt  = tk ? 0 : m_cnt + 1;
            m_below = (m_word < int'(thresh));
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(word) == m_word, m_req, int'(word), m_word);
            chk(below == m_below, "R9", int'(below), int'(m_below));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        chk(word == FULL[W-1:0] && !below, "R1", int'(word), FULL);
        rst_n = 1'b1;
        cyc(2);
        chk(int'(word) == FULL, "R1", int'(word), FULL);

        // Preheat: peak high at full scale must clip (R3, R7)
        mode = 2'b01; peak = 1'b1;
        cyc(100);
        chk(int'(word) == FULL, "R7", int'(word), FULL);
        // Preheat slow fall then bursts (R2, R3)
        peak = 1'b0;
        cyc(400);
        chk(int'(word) == FULL - 100, "R2", int'(word), FULL - 100);
        for (int k = 0; k < 20; k++) begin
            peak = 1'b1; phase = k[0]; cyc(6);
            peak = 1'b0; cyc(40);
        end
        phase = 1'b0;

        // Restart and exact first-tick edge with limit 4 (R8)
        mode = 2'b00; cyc(2);
        limit = 8'd4; mode = 2'b01; peak = 1'b0;
        cyc(4);
        chk(int'(word) == FULL, "R8", int'(word), FULL);
        cyc(1);
        chk(int'(word) == FULL - 1, "R8", int'(word), FULL - 1);

        // Ignition to zero, peak ignored (R4, R7, R9)
        limit = 8'd0; mode = 2'b10;
        for (int k = 0; k < 5000; k++) begin
            peak = k[3]; cyc(1);
        end
        peak = 1'b0;
        chk(int'(word) == 0, "R7", int'(word), 0);
        chk(below == 1'b1, "R9", int'(below), 1);

        // Dim with steady nudges: must climb and clip (R6, R7)
        limit = 8'd2; mode = 2'b11; phase = 1'b1;
        cyc(2000);
        chk(int'(word) == FULL, "R7", int'(word), FULL);
        // Dim with sparse nudges, threshold moves (R5, R6, R9)
        for (int k = 0; k < 4000; k++) begin
            phase = (($urandom % 4) == 0);
            if (k == 2000) thresh = 12'd3900;
            cyc(1);
        end
        phase = 1'b0;
        // One-cycle clear inside dim (R1)
        clear = 1'b1; cyc(1); clear = 1'b0;
        chk(int'(word) == FULL && !below, "R1", int'(word), FULL);
        cyc(300);

        mode = 2'b00; cyc(3);
        chk(int'(word) == FULL, "R1", int'(word), FULL);
        finish_run();
    end

endmodule